// File: doc/BRIEF.md
# Ballast Controller Mode Sequencer

This block is the digital mode sequencer of a fluorescent lamp ballast controller. It reads comparator flags that are already digitized and synchronous: two supply-voltage thresholds, two shutdown-pin thresholds, an end-of-life window violation, a DC bus undervoltage flag, the timing-capacitor threshold crossing and an over-current fault request. From these it steps the ballast through lockout, filament preheat, ignition, steady run and a latched fault state.

Its outputs are one registered enable for the high-side, low-side and PFC gate drivers, two discharge commands (one for the timing capacitor, one for the oscillator control node) and a 3-bit mode code. Each protection is acted on only in the modes where it applies. A latched fault is cleared by a supply dip or by a shutdown-pin excursion, which models lamp removal followed by re-insertion.

Top module: `ballast_seq`

## Requirements
- R1: While rst_ni is low, mode_o is 0 and drv_en_o, cph_dis_o and vco_dis_o are all 0. The reset is asynchronous.
- R2: mode_o encodes the state as 0 lockout, 1 preheat, 2 ignition, 3 run and 4 fault, and no other value appears. drv_en_o is registered and changes on the same clock edge as mode_o.
- R3: In lockout, the block enters preheat on a clock edge where vcc_hi_i=1, sd_lo_i=1 and sd_hi_i was 1 at an earlier edge since the block last left an active mode. Without that shutdown excursion, or with vcc_hi_i=0, it stays in lockout.
- R4: A rising edge of cph_cross_i (sampled 0, then 1 on the next edge) moves preheat to ignition and ignition to run. A level held high advances the mode only once.
- R5: oc_fault_i=1 in preheat or run enters fault at the next edge. In ignition it has no effect.
- R6: eol_i=1 in run enters fault at the next edge. In preheat and ignition it has no effect.
- R7: bus_low_i=1 in run drives drv_en_o to 0 at the next edge while mode_o stays 3. The enable returns when the flag clears. Outside run the flag has no effect.
- R8: In fault, drv_en_o is 0 and cph_dis_o and vco_dis_o are both 1. In every other mode both discharge outputs are 0. drv_en_o is 1 in preheat, ignition and run unless R7 applies, and 0 in lockout.
- R9: Fault is left for lockout when sd_hi_i=1 or vcc_ok_i=0. Fault, over-current, bus and capacitor inputs do not end it.
- R10: vcc_ok_i=0 returns the block to lockout at the next edge from any mode, with priority over every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_hi_i | input | 1 | Supply above upper undervoltage threshold |
| vcc_ok_i | input | 1 | Supply above lower undervoltage threshold |
| sd_hi_i | input | 1 | Shutdown pin above 5 V |
| sd_lo_i | input | 1 | Shutdown pin below 3 V |
| eol_i | input | 1 | End-of-life window violation |
| bus_low_i | input | 1 | DC bus below 3 V |
| cph_cross_i | input | 1 | Timing capacitor above its threshold |
| oc_fault_i | input | 1 | Over-current fault request |
| drv_en_o | output | 1 | Enable for high-side, low-side and PFC drivers |
| cph_dis_o | output | 1 | Discharge timing capacitor |
| vco_dis_o | output | 1 | Discharge oscillator control node |
| mode_o | output | 3 | Mode code |

## Verification
The mode code is the register itself, so a wrong state shows on mode_o one edge after the input that caused it. A wrongly gated protection also shows as drv_en_o or a discharge output toggling in a mode where it must hold still. A lost or stale shutdown-excursion flag does not show at the moment it goes wrong. It shows only at the next restart attempt, as a lockout that never leaves or leaves too early. The vector sequence therefore includes a restart after fault and a restart attempt with no excursion. A double-counted capacitor edge shows as a jump from preheat straight to run within one cycle of a held crossing.

// File: rtl/ballast_seq_pkg.sv
package ballast_seq_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_UVLO    = 3'd0,
    M_PREHEAT = 3'd1,
    M_IGNITE  = 3'd2,
    M_RUN     = 3'd3,
    M_FAULT   = 3'd4
  } mode_e;

  function automatic logic mode_active(mode_e m);
    return (m == M_PREHEAT) || (m == M_IGNITE) || (m == M_RUN);
  endfunction
endpackage

// File: rtl/ballast_sd_arm.sv
// Remembers a shutdown-pin rise above 5 V until an active mode consumes it
module ballast_sd_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sd_hi_i,
  input  logic clr_i,
  output logic armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_o <= 1'b0;
    else if (sd_hi_i) armed_o <= 1'b1;
    else if (clr_i)   armed_o <= 1'b0;
  end
endmodule

// File: rtl/ballast_edge_det.sv
module ballast_edge_det #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= '0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/ballast_mode_fsm.sv
module ballast_mode_fsm
  import ballast_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vcc_hi_i,
  input  logic  vcc_ok_i,
  input  logic  sd_hi_i,
  input  logic  sd_lo_i,
  input  logic  eol_i,
  input  logic  oc_i,
  input  logic  armed_i,
  input  logic  cph_rise_i,
  output mode_e state_o,
  output mode_e nxt_o
);
  mode_e state_q, nxt;

  always_comb begin
    nxt = state_q;
    if (!vcc_ok_i) begin
      nxt = M_UVLO;
    end else begin
      case (state_q)
        M_UVLO:    if (vcc_hi_i && armed_i && sd_lo_i) nxt = M_PREHEAT;
        M_PREHEAT: if (oc_i) nxt = M_FAULT;
                   else if (cph_rise_i) nxt = M_IGNITE;
        M_IGNITE:  if (cph_rise_i) nxt = M_RUN;
        M_RUN:     if (oc_i || eol_i) nxt = M_FAULT;
        M_FAULT:   if (sd_hi_i) nxt = M_UVLO;
        default:   nxt = M_UVLO;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= M_UVLO;
    else         state_q <= nxt;
  end

  assign state_o = state_q;
  assign nxt_o   = nxt;
endmodule

// File: rtl/ballast_out_reg.sv
// Outputs registered from the next state so they switch with the mode code
module ballast_out_reg
  import ballast_seq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e nxt_i,
  input  logic  bus_low_i,
  output logic  drv_en_o,
  output logic  cph_dis_o,
  output logic  vco_dis_o
);
  logic drv_d, dis_d;

  assign drv_d = mode_active(nxt_i) && !((nxt_i == M_RUN) && bus_low_i);
  assign dis_d = (nxt_i == M_FAULT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_en_o  <= 1'b0;
      cph_dis_o <= 1'b0;
      vco_dis_o <= 1'b0;
    end else begin
      drv_en_o  <= drv_d;
      cph_dis_o <= dis_d;
      vco_dis_o <= dis_d;
    end
  end
endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
  import ballast_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vcc_hi_i,
  input  logic              vcc_ok_i,
  input  logic              sd_hi_i,
  input  logic              sd_lo_i,
  input  logic              eol_i,
  input  logic              bus_low_i,
  input  logic              cph_cross_i,
  input  logic              oc_fault_i,
  output logic              drv_en_o,
  output logic              cph_dis_o,
  output logic              vco_dis_o,
  output logic [MODE_W-1:0] mode_o
);
  mode_e state, nxt;
  logic  armed, cph_rise;

  ballast_sd_arm u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sd_hi_i (sd_hi_i),
    .clr_i   (mode_active(state)),
    .armed_o (armed)
  );

  ballast_edge_det #(.W(1)) u_cph_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (cph_cross_i),
    .rise_o (cph_rise)
  );

  ballast_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vcc_hi_i   (vcc_hi_i),
    .vcc_ok_i   (vcc_ok_i),
    .sd_hi_i    (sd_hi_i),
    .sd_lo_i    (sd_lo_i),
    .eol_i      (eol_i),
    .oc_i       (oc_fault_i),
    .armed_i    (armed),
    .cph_rise_i (cph_rise),
    .state_o    (state),
    .nxt_o      (nxt)
  );

  ballast_out_reg u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .nxt_i     (nxt),
    .bus_low_i (bus_low_i),
    .drv_en_o  (drv_en_o),
    .cph_dis_o (cph_dis_o),
    .vco_dis_o (vco_dis_o)
  );

  assign mode_o = state;
endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       vcc_ok_i,
  input logic       eol_i,
  input logic       bus_low_i,
  input logic       oc_fault_i,
  input logic       drv_en_o,
  input logic       cph_dis_o,
  input logic       vco_dis_o,
  input logic [2:0] mode_o
);
  // R2
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd4);

  // R8
  idle_drv_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 || mode_o == 3'd4) |-> !drv_en_o);

  // R8
  fault_discharge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) == (cph_dis_o && vco_dis_o));

  // R10
  supply_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_ok_i |=> (mode_o == 3'd0));

  // R6
  run_eol_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && eol_i && vcc_ok_i) |=> (mode_o == 3'd4));

  // R5
  ignite_oc_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd2 && oc_fault_i && vcc_ok_i) |=> (mode_o != 3'd4));

  // R7
  bus_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && bus_low_i && vcc_ok_i && !eol_i && !oc_fault_i)
      |=> (mode_o == 3'd3 && !drv_en_o));
endmodule

bind ballast_seq ballast_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vcc_ok_i   (vcc_ok_i),
  .eol_i      (eol_i),
  .bus_low_i  (bus_low_i),
  .oc_fault_i (oc_fault_i),
  .drv_en_o   (drv_en_o),
  .cph_dis_o  (cph_dis_o),
  .vco_dis_o  (vco_dis_o),
  .mode_o     (mode_o)
);

// File: tb/ballast_seq_bench.sv
`timescale 1ns/1ps
module ballast_seq_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic vcc_hi = 0, vcc_ok = 0, sd_hi = 0, sd_lo = 0;
  logic eol = 0, bus_low = 0, cph = 0, oc = 0;
  logic drv_en, cph_dis, vco_dis;
  logic [2:0] mode;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ballast_seq u_ballast_seq (
    .clk_i(clk), .rst_ni(rst_ni), .vcc_hi_i(vcc_hi), .vcc_ok_i(vcc_ok),
    .sd_hi_i(sd_hi), .sd_lo_i(sd_lo), .eol_i(eol), .bus_low_i(bus_low),
    .cph_cross_i(cph), .oc_fault_i(oc), .drv_en_o(drv_en),
    .cph_dis_o(cph_dis), .vco_dis_o(vco_dis), .mode_o(mode)
  );

  // {vcc_hi,vcc_ok,sd_hi,sd_lo,eol,bus_low,cph,oc, exp_mode[2:0], exp_drv, exp_dis}
  localparam int NV = 20;
  localparam logic [12:0] VEC [NV] = '{
    {8'b1101_0000, 3'd0, 1'b0, 1'b0},  // R3 no excursion: stay
    {8'b1110_0000, 3'd0, 1'b0, 1'b0},  // R3 sd above 5 V arms
    {8'b1101_0000, 3'd1, 1'b1, 1'b0},  // R3 back below 3 V: preheat
    {8'b1101_1000, 3'd1, 1'b1, 1'b0},  // R6 eol ignored in preheat
    {8'b1101_0100, 3'd1, 1'b1, 1'b0},  // R7 bus ignored in preheat
    {8'b1101_0010, 3'd2, 1'b1, 1'b0},  // R4 first crossing: ignition
    {8'b1101_0010, 3'd2, 1'b1, 1'b0},  // R4 held level no advance
    {8'b1101_0011, 3'd2, 1'b1, 1'b0},  // R5 oc ignored in ignition
    {8'b1101_0000, 3'd2, 1'b1, 1'b0},  // R4
    {8'b1101_0010, 3'd3, 1'b1, 1'b0},  // R4 second crossing: run
    {8'b1101_0100, 3'd3, 1'b0, 1'b0},  // R7 bus low gates enable
    {8'b1101_0000, 3'd3, 1'b1, 1'b0},  // R7 enable resumes
    {8'b1101_1000, 3'd4, 1'b0, 1'b1},  // R6 eol in run: fault
    {8'b1101_0000, 3'd4, 1'b0, 1'b1},  // R9 fault latched
    {8'b1101_1111, 3'd4, 1'b0, 1'b1},  // R9 other inputs do not exit
    {8'b1110_0000, 3'd0, 1'b0, 1'b0},  // R9 sd above 5 V exits
    {8'b1101_0000, 3'd1, 1'b1, 1'b0},  // R3 restart after excursion
    {8'b1101_0001, 3'd4, 1'b0, 1'b1},  // R5 oc in preheat: fault
    {8'b0001_0000, 3'd0, 1'b0, 1'b0},  // R10 supply dip exits fault
    {8'b1101_0000, 3'd0, 1'b0, 1'b0}   // R3 arm consumed: stay
  };

  task automatic check(input string req, input logic [2:0] em, input logic ed,
                       input logic es);
    n_chk++;
    if (mode !== em || drv_en !== ed || cph_dis !== es || vco_dis !== es) begin
      n_bad++;
      $display("FAIL %s: mode=%0d drv=%b cdis=%b vdis=%b expected mode=%0d drv=%b dis=%b",
               req, mode, drv_en, cph_dis, vco_dis, em, ed, es);
    end
  endtask

  task automatic drive(input logic [7:0] v);
    {vcc_hi, vcc_ok, sd_hi, sd_lo, eol, bus_low, cph, oc} = v;
  endtask

  task automatic step(input logic [7:0] v);
    drive(v);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_run();
    step(8'b1110_0000);
    step(8'b1101_0000);
    step(8'b1101_0010);
    step(8'b1101_0000);
    step(8'b1101_0010);
    step(8'b1101_0000);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    drive(8'b1101_0000);
    repeat (3) @(negedge clk);
    check("R1 reset state", 3'd0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12:5]);
      check($sformatf("vector %0d", i), VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end

    // R10 supply drop from run, with oc also present
    go_run();
    check("R2 run reached", 3'd3, 1'b1, 1'b0);
    step(8'b0001_0001);
    check("R10 drop from run beats oc", 3'd0, 1'b0, 1'b0);

    // R3 armed but upper threshold not met
    step(8'b1110_0000);
    step(8'b0101_0000);
    check("R3 vcc_hi low holds lockout", 3'd0, 1'b0, 1'b0);
    step(8'b1101_0000);
    check("R3 vcc_hi rises: preheat", 3'd1, 1'b1, 1'b0);

    // R10 drop from preheat while oc requested
    step(8'b0001_0001);
    check("R10 drop from preheat beats oc", 3'd0, 1'b0, 1'b0);

    // R5 oc in run
    go_run();
    step(8'b1101_0001);
    check("R5 oc in run: fault", 3'd4, 1'b0, 1'b1);

    // R1 asynchronous reset out of fault
    #3 rst_ni = 1'b0;
    #1 check("R1 async reset from fault", 3'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(8'b1101_0000);
    check("R1 reset clears arm", 3'd0, 1'b0, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule